// File: doc/BRIEF.md
# Extended Graphics Register Gate

This block is the control front end of a planar graphics acceleration unit. It holds a bank of single-bit mode flags that software sets through a one-byte mode port. It works out whether the extended unit may run, from a static board strap together with one of those flags. It also keeps the unit's eight 16-bit control registers, which software writes one byte at a time.

Register writes are accepted only while the unit is enabled and the plane-charger mode input is set. Writes to the mask register are also refused while either of two bits of the colour-select register is set. Each accepted byte written to the shift or length register produces a one-cycle recalculate pulse for the shifter, which lies outside this block. Memory reads through the unit return zero and memory writes are blocked while the unit is disabled.

Top module: `egr_gate`

## Requirements
- R1: After reset, access reads 0xFFF0, colour-select reads 0x00FF, and operation, foreground, mask, background, shift and length read 0. All mode flags are 0, the unit is disabled and the recalculate pulse is low.
- R2: A mode-port write stores bit 0 of the byte into the flag indexed by bits 7:1. The new value is visible on the cycle after the write, and all other flags keep their value.
- R3: The unit is enabled exactly when the strap input is 1 and flag index 2 (EXT_FLAG_IDX) is 1. While the strap is 0, any write to flag 2 stores 0.
- R4: Register byte address bits 3:1 select the register, in this order: 0 access, 1 colour-select, 2 operation, 3 foreground, 4 mask, 5 background, 6 shift, 7 length. Address bit 0 picks the low byte (0) or the high byte (1). An accepted write is visible on the next cycle, and the other byte of the register is unchanged.
- R5: A register byte write is ignored unless the charger mode input is 1 and the unit is enabled at the time of the write.
- R6: A write to either mask byte is ignored while bit 14 or bit 13 of the colour-select register is 1.
- R7: Each accepted write to any byte of the shift or length register drives the recalculate output high for exactly the following cycle. Other writes and refused writes leave it low.
- R8: While the unit is disabled, the memory read data output is 0 and the memory write strobe output is 0. While it is enabled, both pass their inputs through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_allow_i | input | 1 | Static board option that permits the extended unit |
| cg_mode_i | input | 1 | Plane-charger mode enable |
| mode_we_i | input | 1 | Mode port write strobe |
| mode_data_i | input | 8 | Mode byte: flag index in 7:1, value in 0 |
| reg_we_i | input | 1 | Register byte write strobe |
| reg_addr_i | input | 4 | Register byte address |
| reg_data_i | input | 8 | Register byte data |
| mem_rdata_i | input | 16 | Read data from the unit's datapath |
| mem_we_i | input | 1 | Memory write strobe toward the datapath |
| mem_rdata_o | output | 16 | Gated read data |
| mem_we_o | output | 1 | Gated write strobe |
| unit_en_o | output | 1 | Extended unit active |
| mode_flags_o | output | 128 | All mode flags |
| access_o | output | 16 | Access register |
| fgbg_o | output | 16 | Colour-select register |
| ope_o | output | 16 | Operation register |
| fg_o | output | 16 | Foreground register |
| mask_o | output | 16 | Mask register |
| bg_o | output | 16 | Background register |
| shift_o | output | 16 | Shift register |
| len_o | output | 16 | Length register |
| recalc_o | output | 1 | Shift parameter recalculate pulse |

## Verification
A wrong enable state shows up at once. Register writes that should stick do not (or stray ones do), and the gated memory read data turns to zero or leaks, within the same cycle the enable is wrong. A mis-decoded byte lane or register select changes a register output on the cycle after the write. Wrong mask blocking or a missing recalculate pulse also appears one cycle after the offending write. Each cycle of the random run is therefore compared against the model of all eight registers, the enable, the pulse and the gated outputs.

// File: rtl/egr_pkg.sv
package egr_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned NUM_REGS = 8;

  typedef logic [REG_W-1:0] word_t;

  typedef enum logic [2:0] {
    R_ACCESS = 3'd0,
    R_FGBG   = 3'd1,
    R_OPE    = 3'd2,
    R_FG     = 3'd3,
    R_MASK   = 3'd4,
    R_BG     = 3'd5,
    R_SHIFT  = 3'd6,
    R_LEN    = 3'd7
  } reg_sel_e;

  localparam word_t RST_ACCESS = 16'hFFF0;
  localparam word_t RST_FGBG   = 16'h00FF;

  function automatic word_t reset_value(input int unsigned idx);
    case (idx)
      0:       return RST_ACCESS;
      1:       return RST_FGBG;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/egr_mode_flags.sv
module egr_mode_flags #(
  parameter int unsigned NUM_FLAGS    = 128,
  parameter int unsigned EXT_FLAG_IDX = 2,
  localparam int unsigned IDX_W       = $clog2(NUM_FLAGS),
  localparam int unsigned BYTE_W      = IDX_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strap_allow_i,
  input  logic                 we_i,
  input  logic [BYTE_W-1:0]    data_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 unit_en_o
);
  logic [IDX_W-1:0] idx;
  logic             val;

  assign idx = data_i[BYTE_W-1:1];
  assign val = data_i[0];

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    logic nxt;
    if (g == EXT_FLAG_IDX) begin : g_ext
      assign nxt = val & strap_allow_i;  // strap forces ext flag low
    end else begin : g_plain
      assign nxt = val;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             flags_o[g] <= 1'b0;
      else if (we_i && idx == IDX_W'(g))       flags_o[g] <= nxt;
    end
  end

  assign unit_en_o = strap_allow_i & flags_o[EXT_FLAG_IDX];

  AST_EXT_FLAG_STRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !strap_allow_i && idx == IDX_W'(EXT_FLAG_IDX)) |=> !flags_o[EXT_FLAG_IDX]); // R3

  AST_FLAG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx != IDX_W'(EXT_FLAG_IDX)) |=> flags_o[$past(idx)] == $past(val)); // R2
endmodule

// File: rtl/egr_reg_bank.sv
module egr_reg_bank
  import egr_pkg::*;
#(
  parameter int unsigned MASK_LOCK_HI = 14,
  parameter int unsigned MASK_LOCK_LO = 13,
  localparam int unsigned ADDR_W      = $clog2(NUM_REGS * 2)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_ok_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [7:0]                data_i,
  output logic [NUM_REGS-1:0][REG_W-1:0] regs_o,
  output logic                      recalc_o
);
  logic       accept;
  logic [2:0] sel;
  logic       hi;
  logic       mask_lock;

  assign sel       = addr_i[ADDR_W-1:1];
  assign hi        = addr_i[0];
  assign mask_lock = regs_o[R_FGBG][MASK_LOCK_HI] | regs_o[R_FGBG][MASK_LOCK_LO];
  assign accept    = we_i & wr_ok_i;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    if (g == int'(R_MASK)) begin : g_mask
      assign hit = accept && sel == 3'(g) && !mask_lock;
    end else begin : g_std
      assign hit = accept && sel == 3'(g);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_o[g] <= reset_value(g);
      else if (hit) begin
        if (hi) regs_o[g][15:8] <= data_i;
        else    regs_o[g][7:0]  <= data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) recalc_o <= 1'b0;
    else         recalc_o <= accept && (sel == R_SHIFT || sel == R_LEN);
  end

  AST_GATED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wr_ok_i) |=> $stable(regs_o)); // R5

  AST_MASK_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == R_MASK && mask_lock) |=> $stable(regs_o[R_MASK])); // R6

  AST_RECALC_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recalc_o |-> $past(we_i && wr_ok_i && sel[2:1] == 2'b11)); // R7
endmodule

// File: rtl/egr_mem_gate.sv
module egr_mem_gate #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              en_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              we_o
);
  assign rdata_o = en_i ? rdata_i : '0;
  assign we_o    = en_i & we_i;
endmodule

// File: rtl/egr_gate.sv
module egr_gate
  import egr_pkg::*;
#(
  parameter int unsigned NUM_FLAGS    = 128,
  parameter int unsigned EXT_FLAG_IDX = 2,
  parameter int unsigned MEM_W        = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strap_allow_i,
  input  logic                 cg_mode_i,
  input  logic                 mode_we_i,
  input  logic [7:0]           mode_data_i,
  input  logic                 reg_we_i,
  input  logic [3:0]           reg_addr_i,
  input  logic [7:0]           reg_data_i,
  input  logic [MEM_W-1:0]     mem_rdata_i,
  input  logic                 mem_we_i,
  output logic [MEM_W-1:0]     mem_rdata_o,
  output logic                 mem_we_o,
  output logic                 unit_en_o,
  output logic [NUM_FLAGS-1:0] mode_flags_o,
  output logic [15:0]          access_o,
  output logic [15:0]          fgbg_o,
  output logic [15:0]          ope_o,
  output logic [15:0]          fg_o,
  output logic [15:0]          mask_o,
  output logic [15:0]          bg_o,
  output logic [15:0]          shift_o,
  output logic [15:0]          len_o,
  output logic                 recalc_o
);
  logic [NUM_REGS-1:0][REG_W-1:0] regs;

  egr_mode_flags #(
    .NUM_FLAGS   (NUM_FLAGS),
    .EXT_FLAG_IDX(EXT_FLAG_IDX)
  ) u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .strap_allow_i(strap_allow_i),
    .we_i         (mode_we_i),
    .data_i       (mode_data_i),
    .flags_o      (mode_flags_o),
    .unit_en_o    (unit_en_o)
  );

  egr_reg_bank u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_ok_i (cg_mode_i & unit_en_o),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .data_i  (reg_data_i),
    .regs_o  (regs),
    .recalc_o(recalc_o)
  );

  egr_mem_gate #(.DATA_W(MEM_W)) u_mem (
    .en_i   (unit_en_o),
    .rdata_i(mem_rdata_i),
    .we_i   (mem_we_i),
    .rdata_o(mem_rdata_o),
    .we_o   (mem_we_o)
  );

  assign access_o = regs[R_ACCESS];
  assign fgbg_o   = regs[R_FGBG];
  assign ope_o    = regs[R_OPE];
  assign fg_o     = regs[R_FG];
  assign mask_o   = regs[R_MASK];
  assign bg_o     = regs[R_BG];
  assign shift_o  = regs[R_SHIFT];
  assign len_o    = regs[R_LEN];

  AST_MEM_WE_NEEDS_STRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (strap_allow_i && mode_flags_o[EXT_FLAG_IDX])); // R8

  AST_MEM_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_flags_o[EXT_FLAG_IDX] |-> mem_rdata_o == '0); // R8
endmodule

// File: tb/egr_gate_bench.sv
module egr_gate_bench;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        strap_allow_i = 1;
  logic        cg_mode_i = 0;
  logic        mode_we_i = 0;
  logic [7:0]  mode_data_i = 0;
  logic        reg_we_i = 0;
  logic [3:0]  reg_addr_i = 0;
  logic [7:0]  reg_data_i = 0;
  logic [15:0] mem_rdata_i = 0;
  logic        mem_we_i = 0;
  logic [15:0] mem_rdata_o;
  logic        mem_we_o;
  logic        unit_en_o;
  logic [127:0] mode_flags_o;
  logic [15:0] access_o, fgbg_o, ope_o, fg_o, mask_o, bg_o, shift_o, len_o;
  logic        recalc_o;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_regs [8];
  logic [127:0] m_flags;
  logic        m_recalc;

  egr_gate u_egr_gate (.*);

  always #2.5 clk_i = ~clk_i;

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rst_val(input int i);
    return (i == 0) ? 16'hFFF0 : (i == 1) ? 16'h00FF : 16'h0;
  endfunction

  function automatic logic exp_en();
    return strap_allow_i && m_flags[2];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_regs[i] = rst_val(i);
    m_flags = '0;
    m_recalc = 0;
  endtask

  // apply current inputs on the model as at a clock edge
  task automatic model_step();
    logic acc;
    int   s;
    acc = reg_we_i && cg_mode_i && exp_en();
    s = int'(reg_addr_i[3:1]);
    m_recalc = acc && (s >= 6);
    if (acc && !(s == 4 && (m_regs[1][14] || m_regs[1][13]))) begin
      if (reg_addr_i[0]) m_regs[s][15:8] = reg_data_i;
      else               m_regs[s][7:0]  = reg_data_i;
    end
    if (mode_we_i) begin
      if (mode_data_i[7:1] == 7'd2) m_flags[2] = mode_data_i[0] & strap_allow_i;
      else                          m_flags[mode_data_i[7:1]] = mode_data_i[0];
    end
  endtask

  task automatic compare_all();
    chk("R4 access", access_o, m_regs[0]);
    chk("R4 fgbg",   fgbg_o,   m_regs[1]);
    chk("R4 ope",    ope_o,    m_regs[2]);
    chk("R4 fg",     fg_o,     m_regs[3]);
    chk("R6 mask",   mask_o,   m_regs[4]);
    chk("R4 bg",     bg_o,     m_regs[5]);
    chk("R7 shift",  shift_o,  m_regs[6]);
    chk("R7 len",    len_o,    m_regs[7]);
    chk("R2 flags",  mode_flags_o, m_flags);
    chk("R3 enable", unit_en_o, exp_en());
    chk("R7 recalc", recalc_o, m_recalc);
    chk("R8 rdata",  mem_rdata_o, exp_en() ? mem_rdata_i : 16'h0);
    chk("R8 we",     mem_we_o, exp_en() & mem_we_i);
  endtask

  // inputs set at negedge, edge, compare at next negedge
  task automatic cycle();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic idle();
    mode_we_i = 0; reg_we_i = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    idle();
    repeat (3) @(negedge clk_i);
    model_reset();
    // R1 reset state
    compare_all();
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic mode_wr(input logic [6:0] idx, input logic v);
    idle(); mode_we_i = 1; mode_data_i = {idx, v}; cycle(); idle();
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    idle(); reg_we_i = 1; reg_addr_i = a; reg_data_i = d; cycle(); idle();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    strap_allow_i = 1;
    do_reset();

    // R5: disabled unit ignores register writes
    cg_mode_i = 1;
    reg_wr(4'h0, 8'h12);
    chk("R5 write while disabled", access_o, 16'hFFF0);
    // R2/R3 enable
    mode_wr(7'd2, 1'b1);
    chk("R3 enabled", unit_en_o, 1'b1);
    // R5: charger mode off
    cg_mode_i = 0;
    reg_wr(4'h4, 8'h77);
    chk("R5 cg off", ope_o, 16'h0);
    cg_mode_i = 1;
    // R4 byte lanes
    reg_wr(4'h7, 8'hA5);
    chk("R4 fg high byte", fg_o, 16'hA500);
    // R7 pulse after shift write, then drop
    reg_wr(4'hC, 8'h03);
    chk("R7 pulse", recalc_o, 1'b1);
    cycle();
    chk("R7 single cycle", recalc_o, 1'b0);
    reg_wr(4'h2, 8'h00);
    chk("R7 no pulse for fgbg", recalc_o, 1'b0);
    // R6 mask lock via bit 13
    reg_wr(4'h3, 8'h20);
    reg_wr(4'h8, 8'hCC);
    chk("R6 mask locked", mask_o, 16'h0000);
    reg_wr(4'h3, 8'h00);
    reg_wr(4'h9, 8'hCC);
    chk("R6 mask unlocked", mask_o, 16'hCC00);
    // R8 pass-through and block
    mem_rdata_i = 16'hBEEF; mem_we_i = 1;
    cycle();
    chk("R8 enabled read", mem_rdata_o, 16'hBEEF);
    mode_wr(7'd2, 1'b0);
    chk("R8 disabled read", mem_rdata_o, 16'h0);
    chk("R8 disabled write", mem_we_o, 1'b0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      mode_we_i   = (r < 12);
      mode_data_i = ($urandom_range(0, 1) != 0) ? {7'd2, ($urandom_range(0, 3) != 0)} : 8'($urandom);
      reg_we_i    = ($urandom_range(0, 99) < 60);
      reg_addr_i  = 4'($urandom);
      reg_data_i  = 8'($urandom);
      cg_mode_i   = ($urandom_range(0, 9) != 0);
      mem_rdata_i = 16'($urandom);
      mem_we_i    = 1'($urandom);
      cycle();
    end

    // R3: strap low forbids the unit
    strap_allow_i = 0;
    do_reset();
    cg_mode_i = 1;
    mode_wr(7'd2, 1'b1);
    chk("R3 strap forces flag 0", mode_flags_o[2], 1'b0);
    chk("R3 strap disabled", unit_en_o, 1'b0);
    mode_wr(7'd5, 1'b1);
    chk("R2 other flag set", mode_flags_o[5], 1'b1);
    reg_wr(4'hE, 8'h11);
    chk("R5 strap low write ignored", len_o, 16'h0);
    chk("R7 no pulse when refused", recalc_o, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule